// File: doc/BRIEF.md
# Watch stepping motor controller

A synchronous controller for the seconds train of an analog watch. It runs on a 32768 Hz crystal clock and divides that clock down to a slow motor cycle. On every cycle boundary it issues one drive pulse of fixed width to a bipolar stepping motor through two complementary outputs. The low side swaps from one pulse to the next, so the rotor always sees a reversed field. A 512 Hz square wave leaves the block on a tuning output so the crystal can be trimmed with a high-impedance probe.

Two slow pad inputs change the behaviour. The stop pad halts stepping so the hands can be set. While it is asserted, the low stages of the divider are held cleared and no new pulse may begin. A pulse that is already running still finishes. After release, the next pulse comes half a motor cycle later, on the other output. The fast pad replaces the motor cycle with a much shorter one so the gear train can be tested quickly. The pulse width does not change. Both pads pass through a two-flop synchroniser and a debounce counter. The cycle time, pulse width, fast cycle time and debounce lengths are fixed at elaboration.

Top module: `watch_step_ctrl`

## Requirements
- R1: While rst_n is low and on the first edges after it rises, drv_a and drv_b are both 1 and tune_out is 0. The first pulse after reset lowers drv_a (side A).
- R2: When fast mode is not active, tune_out toggles every 2^TUNE_BIT clocks (32 clocks by default, 512 Hz). While fast mode is active, tune_out is held at 0.
- R3: In normal mode, successive pulse starts are exactly CYCLE_SEC * 2^SEC_LOG2 clocks apart.
- R4: Every pulse holds one output low for exactly PULSE_UNITS * 2^UNIT_LOG2 clocks, in both modes.
- R5: Between pulses both outputs are 1. The two outputs are never 0 at the same time.
- R6: The low output alternates. A pulse on drv_a is followed by a pulse on drv_b, and the reverse.
- R7: The stop pad takes effect only after HOLD_DB consecutive synchronised high samples. A shorter assertion, or one broken by a low sample, leaves the pulse schedule and tune_out undisturbed.
- R8: While the stop function is active, no new pulse starts and the low CLR_W divider stages are held at zero, so tune_out stays 0.
- R9: A pulse already running when the stop function becomes active still lasts its full width.
- R10: After the stop pad is released, the first pulse starts half a motor cycle later, plus the three-to-four-clock synchroniser and debounce latency. It lands on the output opposite to the last pulse before the stop.
- R11: The fast pad takes effect only after FAST_DB consecutive synchronised high samples. A shorter or interrupted assertion leaves the normal cycle time unchanged.
- R12: While fast mode is active, successive pulse starts are 2^TEST_LOG2 clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz crystal clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| hold_pad | input | 1 | Asynchronous stop pad, active high |
| fast_pad | input | 1 | Asynchronous fast-cycle test pad, active high |
| drv_a | output | 1 | Motor drive A; 0 during a side-A pulse |
| drv_b | output | 1 | Motor drive B; 0 during a side-B pulse |
| tune_out | output | 1 | 512 Hz tuning square wave, 0 in fast mode |

## Verification
A wrong phase count inside the block only becomes visible when the next pulse starts. That can be a full motor cycle after the fault, so the bench measures intervals between pulse starts and does not sample single cycles. A stuck or inverted polarity flop shows at the very next pulse as a repeated low side. A faulty pulse timer shows when the outputs return high, within one pulse width. A debouncer that fires early shows within a few dozen clocks: tune_out stops toggling or the next interval shrinks. Releasing the stop pad tests the preset phase, because the first pulse must arrive after half a cycle and not a whole one.

// File: rtl/wsc_pkg.sv
// Package: shared types for the watch stepping motor controller.
// Assumes a single clock domain; holds only the drive-side encoding.
package wsc_pkg;

    // Which output is pulled low during a pulse.
    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

endpackage

// File: rtl/wsc_pad_filter.sv
// Module: wsc_pad_filter
// Synchronises one asynchronous pad and reports it active once it has been
// high for THRESH consecutive synchronised samples. Any low sample clears
// the count and drops the active flag on the next edge.
// Assumes THRESH >= 1 and a pad that changes far slower than clk.
module wsc_pad_filter #(
    parameter int THRESH = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad,
    output logic active
);
    localparam int CNT_W = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(THRESH - 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic             act_q;

    // Two-flop synchroniser on the pad.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], pad};
    end

    // Count continuous high samples; saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (!sync_q[1]) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else begin
            if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST)  act_q <= 1'b1;
        end
    end

    assign active = act_q;

endmodule

// File: rtl/wsc_divider.sv
// Module: wsc_divider
// Binary divider chain of DIV_W stages fed by the crystal clock. While the
// stop function is active, the low CLR_W stages are held cleared and no
// carry reaches the upper stages. It emits a unit tick once every
// 2^UNIT_LOG2 clocks and a registered square wave from stage TUNE_BIT.
// Assumes CLR_W > UNIT_LOG2 and CLR_W > TUNE_BIT.
module wsc_divider #(
    parameter int DIV_W     = 21,
    parameter int CLR_W     = 12,
    parameter int UNIT_LOG2 = 5,
    parameter int TUNE_BIT  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic fast,
    output logic unit_tick,
    output logic tune_out
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_d;
    logic [DIV_W-1:0] carry;
    logic             tune_q;

    assign carry[0] = 1'b1;

    generate
        for (genvar i = 1; i < DIV_W; i++) begin : g_carry
            assign carry[i] = carry[i-1] & div_q[i-1];
        end
        for (genvar i = 0; i < DIV_W; i++) begin : g_stage
            if (i < CLR_W) begin : g_low
                assign div_d[i] = hold ? 1'b0 : (div_q[i] ^ carry[i]);
            end else begin : g_high
                assign div_d[i] = div_q[i] ^ (carry[i] & ~hold);
            end
        end
    endgenerate

    // Advance the divider chain.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // Register the tuning wave; silence it in fast mode.
    always_ff @(posedge clk) begin
        if (!rst_n)    tune_q <= 1'b0;
        else if (fast) tune_q <= 1'b0;
        else           tune_q <= div_q[TUNE_BIT];
    end

    assign unit_tick = ~hold & (&div_q[UNIT_LOG2-1:0]);
    assign tune_out  = tune_q;

endmodule

// File: rtl/wsc_cycle.sv
// Module: wsc_cycle
// Counts unit ticks down to the next motor cycle boundary and flags the
// boundary for one clock. In normal mode a cycle is CYCLE_SEC seconds and
// in fast mode 2^TEST_LOG2 clocks. While stopped, the count is parked at
// half the current cycle, so the first boundary after release comes half
// a cycle later.
// Assumes 2^SEC_LOG2 clocks per second and TEST_LOG2 > UNIT_LOG2.
module wsc_cycle #(
    parameter int CYCLE_SEC = 2,
    parameter int SEC_LOG2  = 15,
    parameter int UNIT_LOG2 = 5,
    parameter int TEST_LOG2 = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unit_tick,
    input  logic hold,
    input  logic fast,
    output logic boundary
);
    localparam int NORM_UNITS = CYCLE_SEC * (1 << (SEC_LOG2 - UNIT_LOG2));
    localparam int TEST_UNITS = 1 << (TEST_LOG2 - UNIT_LOG2);
    localparam int MAX_UNITS  = (NORM_UNITS > TEST_UNITS) ? NORM_UNITS : TEST_UNITS;
    localparam int PH_W       = $clog2(MAX_UNITS + 1);
    localparam logic [PH_W-1:0] NORM_L = PH_W'(NORM_UNITS);
    localparam logic [PH_W-1:0] TEST_L = PH_W'(TEST_UNITS);
    localparam logic [PH_W-1:0] ONE    = PH_W'(1);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] cur_len;
    logic            bnd_q;

    // Pick the cycle length for the current mode.
    always_comb begin
        cur_len = fast ? TEST_L : NORM_L;
    end

    // Step the phase count and flag boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= NORM_L >> 1;
            bnd_q <= 1'b0;
        end else begin
            bnd_q <= 1'b0;
            if (hold) begin
                ph_q <= cur_len >> 1;
            end else if (unit_tick) begin
                if (ph_q <= ONE) begin
                    bnd_q <= 1'b1;
                    ph_q  <= cur_len;
                end else if (ph_q > cur_len) begin
                    ph_q <= cur_len;
                end else begin
                    ph_q <= ph_q - ONE;
                end
            end
        end
    end

    assign boundary = bnd_q;

endmodule

// File: rtl/wsc_pulse.sv
// Module: wsc_pulse
// Times one motor pulse of PULSE_UNITS * 2^UNIT_LOG2 clocks from a
// boundary flag and drives the low side given by a polarity flop. The flop
// flips as each pulse ends. Runs from clk directly, so the stop function
// cannot cut a pulse short. Boundaries arriving mid-pulse are dropped.
// Assumes PULSE_UNITS >= 1.
module wsc_pulse
    import wsc_pkg::*;
#(
    parameter int PULSE_UNITS = 7,
    parameter int UNIT_LOG2   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    output logic drv_a,
    output logic drv_b
);
    localparam int PULSE_CLKS = PULSE_UNITS << UNIT_LOG2;
    localparam int PW_W       = $clog2(PULSE_CLKS + 1);
    localparam logic [PW_W-1:0] WIDTH = PW_W'(PULSE_CLKS);
    localparam logic [PW_W-1:0] ONE   = PW_W'(1);

    logic [PW_W-1:0] cnt_q;
    side_e           side_q;
    logic            busy;

    // Run the pulse timer and swap sides at the end of each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            side_q <= SIDE_A;
        end else if (busy) begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) side_q <= (side_q == SIDE_A) ? SIDE_B : SIDE_A;
        end else if (boundary) begin
            cnt_q <= WIDTH;
        end
    end

    assign busy  = (cnt_q != '0);
    assign drv_a = ~(busy & (side_q == SIDE_A));
    assign drv_b = ~(busy & (side_q == SIDE_B));

endmodule

// File: rtl/watch_step_ctrl.sv
// Module: watch_step_ctrl
// Top of the watch stepping motor controller. Filters the stop and fast
// pads, divides the crystal clock, counts motor cycles and forms the
// alternating drive pulses.
// Assumes one 32768 Hz clock domain and a synchronous active-low reset.
module watch_step_ctrl #(
    parameter int DIV_W       = 21,
    parameter int CLR_W       = 12,
    parameter int UNIT_LOG2   = 5,
    parameter int TUNE_BIT    = 5,
    parameter int SEC_LOG2    = 15,
    parameter int CYCLE_SEC   = 2,
    parameter int PULSE_UNITS = 7,
    parameter int TEST_LOG2   = 13,
    parameter int HOLD_DB     = 1024,
    parameter int FAST_DB     = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_pad,
    input  logic fast_pad,
    output logic drv_a,
    output logic drv_b,
    output logic tune_out
);
    logic hold_act;
    logic fast_act;
    logic unit_tick;
    logic bnd;

    wsc_pad_filter #(.THRESH(HOLD_DB)) u_hold (
        .clk(clk), .rst_n(rst_n), .pad(hold_pad), .active(hold_act)
    );

    wsc_pad_filter #(.THRESH(FAST_DB)) u_fast (
        .clk(clk), .rst_n(rst_n), .pad(fast_pad), .active(fast_act)
    );

    wsc_divider #(
        .DIV_W(DIV_W), .CLR_W(CLR_W), .UNIT_LOG2(UNIT_LOG2), .TUNE_BIT(TUNE_BIT)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .hold(hold_act), .fast(fast_act),
        .unit_tick(unit_tick), .tune_out(tune_out)
    );

    wsc_cycle #(
        .CYCLE_SEC(CYCLE_SEC), .SEC_LOG2(SEC_LOG2),
        .UNIT_LOG2(UNIT_LOG2), .TEST_LOG2(TEST_LOG2)
    ) u_cycle (
        .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick),
        .hold(hold_act), .fast(fast_act), .boundary(bnd)
    );

    wsc_pulse #(
        .PULSE_UNITS(PULSE_UNITS), .UNIT_LOG2(UNIT_LOG2)
    ) u_pulse (
        .clk(clk), .rst_n(rst_n), .boundary(bnd), .drv_a(drv_a), .drv_b(drv_b)
    );

endmodule

// File: rtl/wsc_chk.sv
// Module: wsc_chk
// Property checker for watch_step_ctrl, attached by the bind below. Tracks
// pulse widths and the last low side from the ports.
module wsc_chk #(
    parameter int PULSE_CLKS = 224
) (
    input logic clk,
    input logic rst_n,
    input logic drv_a,
    input logic drv_b,
    input logic tune_out,
    input logic hold_act,
    input logic fast_act
);
    logic [31:0] low_cnt;
    logic        a_q, b_q, seen, last_b;

    // Length of the current low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)                 low_cnt <= '0;
        else if (!drv_a || !drv_b)  low_cnt <= low_cnt + 1;
        else                        low_cnt <= '0;
    end

    // Remember which side pulsed last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b1; b_q <= 1'b1; seen <= 1'b0; last_b <= 1'b0;
        end else begin
            a_q <= drv_a;
            b_q <= drv_b;
            if (a_q && !drv_a)      begin seen <= 1'b1; last_b <= 1'b0; end
            else if (b_q && !drv_b) begin seen <= 1'b1; last_b <= 1'b1; end
        end
    end

    // R5
    never_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_a || drv_b);

    // R6
    alt_from_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_a) && seen |-> last_b);

    // R6
    alt_from_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_b) |-> seen && !last_b);

    // R4
    width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_a) || $rose(drv_b) |-> low_cnt == PULSE_CLKS);

    // R8
    hold_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act && $past(hold_act) |=> !$fell(drv_a) && !$fell(drv_b));

    // R8
    hold_tune_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act && $past(hold_act) && $past(hold_act, 2) |-> !tune_out);

    // R2
    fast_tune_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_act && $past(fast_act) |-> !tune_out);

endmodule

bind watch_step_ctrl wsc_chk #(.PULSE_CLKS(PULSE_UNITS << UNIT_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .drv_a(drv_a), .drv_b(drv_b),
    .tune_out(tune_out), .hold_act(hold_act), .fast_act(fast_act)
);

// File: tb/watch_step_ctrl_bench.sv
`timescale 1ns/1ps
module watch_step_ctrl_bench;
    localparam int P_SEC_LOG2  = 8;
    localparam int P_CYCLE_SEC = 2;
    localparam int P_PULSE     = 3;
    localparam int P_TEST_LOG2 = 7;
    localparam int P_HOLD_DB   = 64;
    localparam int P_FAST_DB   = 16;
    localparam int EXP_CYC  = P_CYCLE_SEC << P_SEC_LOG2;  // 512
    localparam int EXP_TEST = 1 << P_TEST_LOG2;           // 128
    localparam int EXP_W    = P_PULSE << 5;               // 96
    localparam int EXP_HALF = EXP_CYC / 2;                // 256

    typedef struct packed { logic fast; logic [15:0] gap; } vec_t;
    localparam vec_t VECS [4] = '{
        '{fast: 1'b1, gap: 16'(EXP_TEST)},
        '{fast: 1'b0, gap: 16'(EXP_CYC)},
        '{fast: 1'b1, gap: 16'(EXP_TEST)},
        '{fast: 1'b0, gap: 16'(EXP_CYC)}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_pad = 1'b0;
    logic fast_pad = 1'b0;
    logic drv_a, drv_b, tune_out;

    int n_checks = 0, n_fail = 0;
    int cyc = 0, n_pulses = 0, last_start = 0, cur_start = 0, last_width = 0;
    int last_side = 0, prev_side = 0, both_low = 0;
    int tune_edges = 0, tune_last = 0, tune_gap = 0;
    logic pa = 1'b1, pb = 1'b1, pt = 1'b0;

    always #2.5 clk = ~clk;

    watch_step_ctrl #(
        .SEC_LOG2(P_SEC_LOG2), .CYCLE_SEC(P_CYCLE_SEC), .PULSE_UNITS(P_PULSE),
        .TEST_LOG2(P_TEST_LOG2), .HOLD_DB(P_HOLD_DB), .FAST_DB(P_FAST_DB)
    ) u_watch_step_ctrl (
        .clk(clk), .rst_n(rst_n), .hold_pad(hold_pad), .fast_pad(fast_pad),
        .drv_a(drv_a), .drv_b(drv_b), .tune_out(tune_out)
    );

    // Port monitor: pulse starts, widths, sides and tuning edges.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!drv_a && !drv_b) both_low++;
            if ((pa && !drv_a) || (pb && !drv_b)) begin
                prev_side = last_side;
                last_side = drv_a ? 1 : 0;
                cur_start = cyc;
                n_pulses++;
            end
            if ((!pa && drv_a) || (!pb && drv_b)) last_width = cyc - cur_start;
            if (pt != tune_out) begin
                tune_gap = cyc - tune_last;
                tune_last = cyc;
                tune_edges++;
            end
        end
        pa = drv_a; pb = drv_b; pt = tune_out;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        int n0 = n_pulses;
        while (n_pulses == n0) @(negedge clk);
        last_start = cur_start;
    endtask

    task automatic wait_quiet();
        while (!drv_a || !drv_b) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int p0, e0, gap;
        idle(10);
        // R1 reset state
        chk(drv_a && drv_b, "R1 drives high in reset", {drv_a, drv_b}, 3);
        chk(!tune_out, "R1 tune low in reset", tune_out, 0);
        rst_n = 1'b1;
        idle(2);
        chk(drv_a && drv_b && !tune_out, "R1 state after reset", {drv_a, drv_b, tune_out}, 6);
        idle(200);
        // R2 tuning half period
        chk(tune_gap == 32, "R2 tune half period", tune_gap, 32);
        wait_pulse();
        chk(last_side == 0, "R1 first pulse side", last_side, 0);
        wait_quiet();
        chk(last_width == EXP_W, "R4 first width", last_width, EXP_W);

        // Table walk: mode, interval, width, alternation
        foreach (VECS[i]) begin
            fast_pad = VECS[i].fast;
            idle(P_FAST_DB + 20);
            wait_pulse();
            wait_pulse();
            p0 = last_start;
            e0 = tune_edges;
            wait_pulse();
            gap = last_start - p0;
            if (VECS[i].fast) begin
                chk(gap == int'(VECS[i].gap), "R12 fast interval", gap, VECS[i].gap);
                chk(tune_edges == e0 && !tune_out, "R2 tune held in fast", tune_edges - e0, 0);
            end else begin
                chk(gap == int'(VECS[i].gap), "R3 normal interval", gap, VECS[i].gap);
                chk(tune_edges > e0, "R2 tune runs", tune_edges - e0, 16);
            end
            chk(last_side != prev_side, "R6 alternating side", last_side, 1 - prev_side);
            wait_quiet();
            chk(last_width == EXP_W, "R4 width in mode", last_width, EXP_W);
        end

        // R7 short stop pulse ignored
        wait_pulse();
        p0 = last_start;
        hold_pad = 1'b1; idle(30); hold_pad = 1'b0;
        e0 = tune_edges;
        idle(100);
        chk(tune_edges > e0, "R7 short stop ignored (tune)", tune_edges - e0, 3);
        // R7 interrupted stop ignored
        hold_pad = 1'b1; idle(50); hold_pad = 1'b0; idle(3);
        hold_pad = 1'b1; idle(50); hold_pad = 1'b0;
        wait_pulse();
        chk(last_start - p0 == EXP_CYC, "R7 schedule kept", last_start - p0, EXP_CYC);

        // R11 short and interrupted fast pulses ignored
        p0 = last_start;
        fast_pad = 1'b1; idle(10); fast_pad = 1'b0; idle(20);
        fast_pad = 1'b1; idle(12); fast_pad = 1'b0; idle(3);
        fast_pad = 1'b1; idle(12); fast_pad = 1'b0;
        wait_pulse();
        chk(last_start - p0 == EXP_CYC, "R11 fast glitch ignored", last_start - p0, EXP_CYC);

        // R8 R9 R10 stop during a running pulse
        wait_pulse();
        hold_pad = 1'b1;
        p0 = n_pulses;
        e0 = last_side;
        idle(200);
        gap = tune_edges;
        idle(1300);
        chk(last_width == EXP_W, "R9 pulse completes under stop", last_width, EXP_W);
        chk(n_pulses == p0, "R8 no pulse while stopped", n_pulses - p0, 0);
        chk(tune_edges == gap && !tune_out, "R8 low stages cleared", tune_edges - gap, 0);
        hold_pad = 1'b0;
        p0 = cyc;
        wait_pulse();
        gap = last_start - p0;
        chk(gap >= EXP_HALF && gap <= EXP_HALF + 16, "R10 half cycle resume", gap, EXP_HALF + 4);
        chk(last_side != e0, "R10 opposite side", last_side, 1 - e0);
        wait_quiet();

        chk(both_low == 0, "R5 never both low", both_low, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule